// File: doc/BRIEF.md
# PCIe Error Status and Reporting Unit

This unit gathers one-cycle error strobes raised by the physical, data link and transaction layers of a PCI Express port, plus a handful of device-specific faults. It sorts each strobe into a correctable, uncorrectable or device-specific class and records it in a sticky status bit at a fixed position. Per-bit masks and an uncorrectable severity register decide what follows. The unit pulses a correctable, non-fatal or fatal message request toward the root complex, and it drives a local interrupt line. For malformed packets and device-specific faults, it also freezes a copy of the offending packet header for software.

Software uses a small word-addressed register port. Plain writes go to masks and severity. Writes to status registers clear each bit written as 1. Reads are combinational from the current register contents. The message requests are meant for a downstream message generator, and the interrupt line goes to the local processor.

Top module: `pcie_err_report`

## Requirements
- R1: After reset, every status, mask, severity, log and interrupt register reads 0. `msg_cor`, `msg_nonfatal`, `msg_fatal` and `irq` are low. Word addresses: 0 correctable status, 1 correctable mask, 2 uncorrectable status, 3 uncorrectable mask, 4 uncorrectable severity, 5 device error status, 6 device error mask, 7 detected summary, 8 unit interrupt status, 9 unit interrupt mask, 10 log control, 11+i header dword i.
- R2: `cor_evt` bits [0..4] (receiver error, bad TLP, bad DLLP, replay-number rollover, replay timeout) set correctable status bits 0, 6, 7, 8 and 12. An unmasked correctable event pulses `msg_cor` for exactly one cycle, on the clock edge that records it.
- R3: `unc_evt` bits [0..2] (training error, data link protocol error, malformed TLP) set uncorrectable status bits 0, 4 and 18. For an unmasked event, `msg_fatal` pulses if its severity bit is 1, and `msg_nonfatal` pulses if it is 0.
- R4: `dev_evt` bits [0..3] (outbound header parity, poisoned TLP sent, completion with CA, completion with UR) set device status bits 28, 29, 30 and 31. They never request a message.
- R5: A set mask bit leaves its status bit recorded. It suppresses that error's message request and its unit interrupt status contribution.
- R6: The detected summary (address 7) is set regardless of mask. Bit 0 is set by any correctable event. Bit 1 is set by an uncorrectable event with severity 0. Bit 2 is set by an uncorrectable event with severity 1.
- R7: Unit interrupt status bit 9 is set by unmasked correctable errors, bit 8 by unmasked uncorrectable errors, and bit 10 by device errors whose device mask bit is 0. `irq` is the OR of these status bits gated by the inverse of the unit interrupt mask (same bit positions).
- R8: All status bits are sticky and are cleared only by writing 1 to them. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: Only one message request is active per cycle, with priority fatal over non-fatal over correctable.
- R10: A malformed TLP or any device error is logged into the header log if the log is empty. The header comes from `hdr_data` if `hdr_valid` is high in that cycle, otherwise from the last header seen with `hdr_valid`. When several such errors arrive together, the malformed TLP wins, then the higher device bit.
- R11: Log control reads bit 31 = log valid, bits [6:5] = bank (1 uncorrectable, 2 device) and bits [4:0] = status bit position. The log stays frozen while the pointed status bit remains set, and it becomes free when that bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cor_evt | input | 5 | Correctable error strobes |
| unc_evt | input | 3 | Uncorrectable error strobes |
| dev_evt | input | 4 | Device-specific error strobes |
| hdr_valid | input | 1 | Header bus holds a valid TLP header |
| hdr_data | input | HDR_W | TLP header, dword 0 in the low bits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| msg_cor | output | 1 | Correctable message request pulse |
| msg_nonfatal | output | 1 | Non-fatal message request pulse |
| msg_fatal | output | 1 | Fatal message request pulse |
| irq | output | 1 | Unit interrupt |

## Verification
The assertions check the following on every cycle:
- at most one message request is active;
- correctable and fatal requests follow their unmasked events;
- device-only events produce no request;
- correctable status bits never drop without a write, and a new event always lands;
- the header log holds still while no write could release it.

Only the directed scenarios show the following:
- the exact bit map of each bank and the severity split;
- the summary bits;
- the interplay of interrupt masks;
- the header source chosen when `hdr_valid` is low;
- the pointer encoding and priority, and the release of the log after a clear.

// File: rtl/pcie_err_report.sv
module pcie_err_report #(
  parameter int HDR_W = 128,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       cor_evt,
  input  logic [2:0]       unc_evt,
  input  logic [3:0]       dev_evt,
  input  logic             hdr_valid,
  input  logic [HDR_W-1:0] hdr_data,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             msg_cor,
  output logic             msg_nonfatal,
  output logic             msg_fatal,
  output logic             irq
);

  localparam int NDW = HDR_W / 32;
  localparam logic [31:0] COR_BITS = 32'h0000_11C1;
  localparam logic [31:0] UNC_BITS = 32'h0004_0011;
  localparam logic [31:0] DEV_BITS = 32'hF000_0000;
  localparam logic [31:0] ISR_BITS = 32'h0000_0700;
  localparam logic [AW-1:0] A_CSTS = AW'(0),  A_CMSK = AW'(1),  A_USTS = AW'(2);
  localparam logic [AW-1:0] A_UMSK = AW'(3),  A_USEV = AW'(4),  A_DSTS = AW'(5);
  localparam logic [AW-1:0] A_DMSK = AW'(6),  A_SUMM = AW'(7),  A_ISR  = AW'(8);
  localparam logic [AW-1:0] A_IMSK = AW'(9),  A_LOG  = AW'(10);
  localparam int A_HDR0 = 11;

  logic [31:0] cor_sts, cor_msk, unc_sts, unc_msk, unc_sev;
  logic [31:0] dev_sts, dev_msk, isr, imsk;
  logic [2:0]  summ;
  logic        log_vld;
  logic [6:0]  log_ptr;
  logic [HDR_W-1:0] log_hdr, last_hdr;

  wire [31:0] cor_set = {19'b0, cor_evt[4], 3'b0, cor_evt[3], cor_evt[2], cor_evt[1], 5'b0, cor_evt[0]};
  wire [31:0] unc_set = {13'b0, unc_evt[2], 13'b0, unc_evt[1], 3'b0, unc_evt[0]};
  wire [31:0] dev_set = {dev_evt, 28'b0};

  function automatic logic [31:0] clr_of(input logic [AW-1:0] a);
    return (reg_wr && reg_addr == a) ? reg_wdata : 32'b0;
  endfunction

  wire [31:0] cor_live = cor_set & ~cor_msk;
  wire [31:0] unc_live = unc_set & ~unc_msk;
  wire [31:0] dev_live = dev_set & ~dev_msk;
  wire        any_fat  = |(unc_live & unc_sev);
  wire        any_nf   = |(unc_live & ~unc_sev);

  wire [31:0] cor_sts_n = (cor_sts & ~clr_of(A_CSTS)) | cor_set;
  wire [31:0] unc_sts_n = (unc_sts & ~clr_of(A_USTS)) | unc_set;
  wire [31:0] dev_sts_n = (dev_sts & ~clr_of(A_DSTS)) | dev_set;
  wire [31:0] isr_n = (isr & ~clr_of(A_ISR)) | {21'b0, |dev_live, |cor_live, |unc_live, 8'b0};
  wire [2:0]  summ_n = (summ & ~clr_of(A_SUMM)) |
                       {|(unc_set & unc_sev), |(unc_set & ~unc_sev), |cor_set};

  logic       lg_hit;
  logic [6:0] ptr_n;
  always_comb begin
    lg_hit = 1'b0;
    ptr_n  = '0;
    for (int i = 28; i < 32; i++)
      if (dev_set[i]) begin
        lg_hit = 1'b1;
        ptr_n  = {2'd2, 5'(i)};
      end
    if (unc_set[18]) begin
      lg_hit = 1'b1;
      ptr_n  = {2'd1, 5'd18};
    end
  end

  wire log_hold = log_vld &&
                  ((log_ptr[6:5] == 2'd1) ? unc_sts_n[log_ptr[4:0]] : dev_sts_n[log_ptr[4:0]]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cor_sts <= '0; cor_msk <= '0; unc_sts <= '0; unc_msk <= '0; unc_sev <= '0;
      dev_sts <= '0; dev_msk <= '0; isr <= '0; imsk <= '0; summ <= '0;
      msg_cor <= 1'b0; msg_nonfatal <= 1'b0; msg_fatal <= 1'b0;
    end else begin
      cor_sts <= cor_sts_n & COR_BITS;
      unc_sts <= unc_sts_n & UNC_BITS;
      dev_sts <= dev_sts_n & DEV_BITS;
      isr     <= isr_n & ISR_BITS;
      summ    <= summ_n;
      if (reg_wr && reg_addr == A_CMSK) cor_msk <= reg_wdata & COR_BITS;
      if (reg_wr && reg_addr == A_UMSK) unc_msk <= reg_wdata & UNC_BITS;
      if (reg_wr && reg_addr == A_USEV) unc_sev <= reg_wdata & UNC_BITS;
      if (reg_wr && reg_addr == A_DMSK) dev_msk <= reg_wdata & DEV_BITS;
      if (reg_wr && reg_addr == A_IMSK) imsk    <= reg_wdata & ISR_BITS;
      msg_fatal    <= any_fat;
      msg_nonfatal <= any_nf && !any_fat;
      msg_cor      <= (|cor_live) && !(|unc_live);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_vld  <= 1'b0;
      log_ptr  <= '0;
      log_hdr  <= '0;
      last_hdr <= '0;
    end else begin
      if (hdr_valid) last_hdr <= hdr_data;
      if (!log_hold) begin
        log_vld <= lg_hit;
        if (lg_hit) begin
          log_ptr <= ptr_n;
          log_hdr <= hdr_valid ? hdr_data : last_hdr;
        end
      end
    end
  end

  assign irq = |(isr & ~imsk);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CSTS: reg_rdata = cor_sts;
      A_CMSK: reg_rdata = cor_msk;
      A_USTS: reg_rdata = unc_sts;
      A_UMSK: reg_rdata = unc_msk;
      A_USEV: reg_rdata = unc_sev;
      A_DSTS: reg_rdata = dev_sts;
      A_DMSK: reg_rdata = dev_msk;
      A_SUMM: reg_rdata = {29'b0, summ};
      A_ISR:  reg_rdata = isr;
      A_IMSK: reg_rdata = imsk;
      A_LOG:  reg_rdata = {log_vld, 24'b0, log_ptr};
      default: reg_rdata = '0;
    endcase
    for (int i = 0; i < NDW; i++)
      if (reg_addr == AW'(A_HDR0 + i)) reg_rdata = log_hdr[32*i +: 32];
  end

  // R9
  msg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_cor, msg_nonfatal, msg_fatal}));

  // R2
  cor_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(cor_set & ~cor_msk)) && !(|(unc_set & ~unc_msk))) |=> msg_cor);

  // R3
  fatal_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(unc_set & ~unc_msk & unc_sev)) |=> msg_fatal);

  // R4
  dev_nomsg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_evt != 4'b0 && unc_evt == 3'b0 && cor_evt == 5'b0) |=> !(msg_cor || msg_nonfatal || msg_fatal));

  // R8
  cor_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_CSTS) |=> ((cor_sts & $past(cor_sts)) == $past(cor_sts)));

  // R8
  cor_setwins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_evt != 5'b0) |=> ((cor_sts & $past(cor_set)) == $past(cor_set)));

  // R11
  log_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_vld && !reg_wr) |=> (log_vld && $stable(log_hdr) && $stable(log_ptr)));

endmodule

// File: tb/pcie_err_report_tb_top.sv
`timescale 1ns/1ps
module pcie_err_report_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] cor_evt = '0;
  logic [2:0] unc_evt = '0;
  logic [3:0] dev_evt = '0;
  logic hdr_valid = 1'b0;
  logic [127:0] hdr_data = '0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic msg_cor, msg_nonfatal, msg_fatal, irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pcie_err_report dut_i (
    .clk(clk), .rst_n(rst_n), .cor_evt(cor_evt), .unc_evt(unc_evt), .dev_evt(dev_evt),
    .hdr_valid(hdr_valid), .hdr_data(hdr_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_cor(msg_cor),
    .msg_nonfatal(msg_nonfatal), .msg_fatal(msg_fatal), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] c, input logic [2:0] u, input logic [3:0] d,
                       input logic hv, input logic [127:0] h);
    @(negedge clk); cor_evt = c; unc_evt = u; dev_evt = d; hdr_valid = hv; hdr_data = h;
    @(negedge clk); cor_evt = '0; unc_evt = '0; dev_evt = '0; hdr_valid = 1'b0;
  endtask

  function automatic logic [31:0] msgs();
    return {29'b0, msg_fatal, msg_nonfatal, msg_cor};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), d);
      chk("R1 register zero after reset", d, 32'h0);
    end
    chk("R1 outputs low after reset", {28'b0, msg_fatal, msg_nonfatal, msg_cor, irq}, 32'h0);
  endtask

  task automatic t_cor();
    logic [31:0] d;
    do_reset();
    pulse(5'b00001, 3'b0, 4'b0, 1'b0, '0);
    chk("R2 msg_cor after receiver error", msgs(), 32'h1);
    @(negedge clk);
    chk("R2 msg_cor one cycle only", msgs(), 32'h0);
    rd(4'd0, d); chk("R2 receiver error bit 0", d, 32'h1);
    pulse(5'b11110, 3'b0, 4'b0, 1'b0, '0);
    rd(4'd0, d); chk("R2 full correctable map", d, 32'h0000_11C1);
    rd(4'd8, d); chk("R7 isr bit 9 from correctable", d, 32'h200);
    chk("R7 irq raised", {31'b0, irq}, 32'h1);
    rd(4'd7, d); chk("R6 summary bit 0", d, 32'h1);
  endtask

  task automatic t_unc();
    logic [31:0] d;
    do_reset();
    wr(4'd4, 32'h0004_0000);
    pulse(5'b0, 3'b001, 4'b0, 1'b0, '0);
    chk("R3 training error nonfatal", msgs(), 32'h2);
    rd(4'd7, d); chk("R6 summary nonfatal bit", d, 32'h2);
    rd(4'd8, d); chk("R7 isr bit 8", d, 32'h100);
    pulse(5'b0, 3'b100, 4'b0, 1'b0, '0);
    chk("R3 malformed fatal", msgs(), 32'h4);
    pulse(5'b0, 3'b010, 4'b0, 1'b0, '0);
    chk("R3 dl protocol nonfatal", msgs(), 32'h2);
    rd(4'd2, d); chk("R3 uncorrectable map", d, 32'h0004_0011);
    rd(4'd7, d); chk("R6 summary fatal bit", d, 32'h6);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    wr(4'd1, 32'h1000);
    wr(4'd3, 32'h10);
    pulse(5'b10000, 3'b0, 4'b0, 1'b0, '0);
    chk("R5 masked correctable no message", msgs(), 32'h0);
    rd(4'd0, d); chk("R5 masked correctable still recorded", d, 32'h1000);
    rd(4'd8, d); chk("R5 masked correctable no isr", d, 32'h0);
    rd(4'd7, d); chk("R6 summary ignores mask", d, 32'h1);
    pulse(5'b0, 3'b010, 4'b0, 1'b0, '0);
    chk("R5 masked uncorrectable no message", msgs(), 32'h0);
    rd(4'd2, d); chk("R5 masked uncorrectable recorded", d, 32'h10);
    rd(4'd8, d); chk("R5 masked uncorrectable no isr", d, 32'h0);
    chk("R5 irq stays low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_prio();
    do_reset();
    wr(4'd4, 32'h0004_0000);
    pulse(5'b00001, 3'b001, 4'b0, 1'b0, '0);
    chk("R9 nonfatal beats correctable", msgs(), 32'h2);
    pulse(5'b00001, 3'b101, 4'b0, 1'b0, '0);
    chk("R9 fatal beats all", msgs(), 32'h4);
  endtask

  task automatic t_dev();
    logic [31:0] d;
    do_reset();
    pulse(5'b0, 3'b0, 4'b1000, 1'b0, '0);
    chk("R4 UR no message", msgs(), 32'h0);
    rd(4'd5, d); chk("R4 UR bit 31", d, 32'h8000_0000);
    rd(4'd8, d); chk("R7 isr bit 10", d, 32'h400);
    chk("R7 irq from device error", {31'b0, irq}, 32'h1);
    wr(4'd8, 32'h400);
    wr(4'd6, 32'h4000_0000);
    pulse(5'b0, 3'b0, 4'b0100, 1'b0, '0);
    rd(4'd5, d); chk("R4 CA bit 30 recorded", d, 32'hC000_0000);
    rd(4'd8, d); chk("R5 device mask blocks isr", d, 32'h0);
    pulse(5'b0, 3'b0, 4'b0011, 1'b0, '0);
    chk("R4 parity and poisoned no message", msgs(), 32'h0);
    rd(4'd5, d); chk("R4 device map", d, 32'hF000_0000);
  endtask

  task automatic t_irqmask();
    logic [31:0] d;
    do_reset();
    wr(4'd9, 32'h200);
    pulse(5'b00100, 3'b0, 4'b0, 1'b0, '0);
    rd(4'd8, d); chk("R7 isr set while masked", d, 32'h200);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    wr(4'd9, 32'h0);
    chk("R7 irq after unmask", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    do_reset();
    pulse(5'b00001, 3'b0, 4'b0, 1'b0, '0);
    @(negedge clk); cor_evt = 5'b00001; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h1;
    @(negedge clk); cor_evt = '0; reg_wr = 1'b0;
    rd(4'd0, d); chk("R8 set wins over clear", d, 32'h1);
    wr(4'd0, 32'h0);
    rd(4'd0, d); chk("R8 write 0 keeps bit", d, 32'h1);
    wr(4'd0, 32'h1);
    rd(4'd0, d); chk("R8 write 1 clears", d, 32'h0);
  endtask

  task automatic t_log();
    logic [31:0] d;
    logic [127:0] h1 = 128'h11112222_33334444_55556666_77778888;
    logic [127:0] h2 = 128'hAAAA0001_BBBB0002_CCCC0003_DDDD0004;
    do_reset();
    pulse(5'b0, 3'b0, 4'b1000, 1'b1, h1);
    rd(4'd10, d); chk("R11 pointer UR", d, 32'h8000_005F);
    for (int i = 0; i < 4; i++) begin
      rd(4'(11 + i), d); chk("R10 header dword h1", d, h1[32*i +: 32]);
    end
    pulse(5'b0, 3'b100, 4'b0, 1'b1, h2);
    rd(4'd10, d); chk("R11 log frozen pointer", d, 32'h8000_005F);
    rd(4'd11, d); chk("R11 log frozen header", d, h1[31:0]);
    wr(4'd5, 32'h8000_0000);
    rd(4'd10, d); chk("R11 log released", {31'b0, d[31]}, 32'h0);
    pulse(5'b0, 3'b0, 4'b0010, 1'b0, '0);
    rd(4'd10, d); chk("R11 pointer poisoned", d, 32'h8000_005D);
    rd(4'd14, d); chk("R10 last valid header used", d, h2[127:96]);
    wr(4'd5, 32'hF000_0000);
    wr(4'd2, 32'hFFFF_FFFF);
    pulse(5'b0, 3'b100, 4'b0100, 1'b1, h1);
    rd(4'd10, d); chk("R10 malformed wins log priority", d, 32'h8000_0032);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_cor();
    t_unc();
    t_mask();
    t_prio();
    t_dev();
    t_irqmask();
    t_w1c();
    t_log();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule